// File: doc/BRIEF.md
# Half-Duplex Collision Indicator with Heartbeat Pulse

This block drives the collision indication of a media-independent interface PHY. It reports a true collision whenever the local transmitter and the receive path are busy together, but only in half duplex. A collision-test mode lets the host check its collision handling without a second station: with the test bit set, the indication follows transmit enable after a fixed delay on both edges. At 10 Mb/s half duplex, the block also sends a short heartbeat pulse on the same output a little after each frame ends. A configuration bit can turn that pulse off.

All delays are counted on a free-running one-cycle `bit_tick` strobe, one strobe per bit time, so one design serves both line rates. Each timer also adds one register stage. The output comes from a register. In full duplex it is held low, whatever the other inputs do.

Top module: `col_sqe_gen`

## Requirements
- R1: In half duplex, when `tx_en` and `rx_act` are both high at a clock edge, `col` is high after that edge. It stays high for as long as the overlap lasts.
- R2: While `full_dup` is high, `col` is low after every clock edge. This holds for true collisions, collision test and the heartbeat alike.
- R3: With `col_test` high, `col` rises at the clock edge one stage after the TEST_ON-th tick (default 16) of continuous `tx_en`. With `bit_tick` high on every cycle, this is the 17th edge that samples `tx_en` high.
- R4: With `col_test` high, `col` falls one stage after the TEST_OFF-th tick (default 2) of `tx_en` low. With `bit_tick` high on every cycle, this is the 3rd edge that samples `tx_en` low.
- R5: When `spd_10` is high, `full_dup` is low and `sqe_off` is low, a falling `tx_en` arms a heartbeat. After SQE_GAP ticks (default 20) plus one stage, `col` goes high for SQE_LEN ticks (default 10). With a tick on every cycle, `col` is high after edges 22 through 31, counting the first edge that samples `tx_en` low as edge 1.
- R6: While `sqe_off` is high, no heartbeat pulse appears on `col`.
- R7: While `spd_10` is low (100 Mb/s), no heartbeat pulse appears on `col`.
- R8: If `tx_en` rises again before the heartbeat has started, that heartbeat is cancelled.
- R9: During and right after synchronous reset (`rst` high), `col` is low.
- R10: The collision-test timers advance only on cycles where `bit_tick` is high. With `bit_tick` held low, collision test never raises `col`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe, once per bit time |
| tx_en | input | 1 | Transmit enable |
| rx_act | input | 1 | Receive activity detected |
| full_dup | input | 1 | 1 = full duplex |
| spd_10 | input | 1 | 1 = 10 Mb/s, 0 = 100 Mb/s |
| col_test | input | 1 | Collision-test enable |
| sqe_off | input | 1 | Suppresses the heartbeat pulse |
| col | output | 1 | Collision indication |

## Verification
The assertions assume that all inputs are synchronous to `clk` and change only between edges. They also assume that `bit_tick` is a plain strobe and that mode bits are not switched in the middle of a heartbeat. The bench drives every input at the falling edge and changes modes only while `tx_en` is low and no heartbeat is pending. For R10 it holds `bit_tick` low for a whole window; everywhere else it keeps `bit_tick` high, so every delay can be counted in clock edges.

// File: rtl/col_pkg.sv
package col_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hb_state_t;
endpackage

// File: rtl/col_test_timer.sv
module col_test_timer #(
  parameter int TEST_ON  = 16,
  parameter int TEST_OFF = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic col_test,
  input  logic tx_en,
  output logic test_act
);
  localparam int ON_W  = $clog2(TEST_ON + 1);
  localparam int OFF_W = $clog2(TEST_OFF + 1);

  logic [ON_W-1:0]  on_cnt;
  logic [OFF_W-1:0] off_cnt;

  always_ff @(posedge clk) begin
    if (rst || !col_test) begin
      on_cnt   <= '0;
      off_cnt  <= '0;
      test_act <= 1'b0;
    end else if (bit_tick) begin
      if (tx_en) begin
        off_cnt <= '0;
        if (!test_act) begin
          if (on_cnt == ON_W'(TEST_ON - 1)) test_act <= 1'b1;
          else                              on_cnt   <= on_cnt + 1'b1;
        end
      end else begin
        on_cnt <= '0;
        if (test_act) begin
          if (off_cnt == OFF_W'(TEST_OFF - 1)) test_act <= 1'b0;
          else                                 off_cnt  <= off_cnt + 1'b1;
        end
      end
    end
  end

  AST_TEST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && col_test) |=> $stable(test_act)); // R10
  AST_TEST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
    !col_test |=> !test_act); // R3
endmodule

// File: rtl/col_sqe_timer.sv
module col_sqe_timer
  import col_pkg::*;
#(
  parameter int SQE_GAP = 20,
  parameter int SQE_LEN = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic tx_en,
  input  logic hb_en,
  output logic sqe_act
);
  localparam int GAP_W = $clog2(SQE_GAP + 1);
  localparam int LEN_W = $clog2(SQE_LEN + 1);
  localparam int CNT_W = (GAP_W > LEN_W) ? GAP_W : LEN_W;

  hb_state_t        state;
  logic [CNT_W-1:0] cnt;
  logic             tx_q;
  logic             tx_fall;

  assign tx_fall = tx_q && !tx_en;
  assign sqe_act = (state == HB_PULSE);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= 1'b0;
      state <= HB_IDLE;
      cnt   <= '0;
    end else begin
      tx_q <= tx_en;
      unique case (state)
        HB_IDLE: begin
          cnt <= '0;
          if (tx_fall && hb_en) state <= HB_WAIT;
        end
        HB_WAIT: begin
          if (tx_en || !hb_en) begin
            state <= HB_IDLE;
          end else if (bit_tick) begin
            if (cnt == CNT_W'(SQE_GAP - 1)) begin
              state <= HB_PULSE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        HB_PULSE: begin
          if (!hb_en) begin
            state <= HB_IDLE;
          end else if (bit_tick) begin
            if (cnt == CNT_W'(SQE_LEN - 1)) state <= HB_IDLE;
            else                            cnt   <= cnt + 1'b1;
          end
        end
        default: state <= HB_IDLE;
      endcase
    end
  end

  AST_SQE_ENABLED: assert property (@(posedge clk) disable iff (rst)
    (state == HB_PULSE) |-> $past(hb_en)); // R7
  AST_SQE_CANCEL: assert property (@(posedge clk) disable iff (rst)
    (state == HB_WAIT && tx_en) |=> (state == HB_IDLE)); // R8
endmodule

// File: rtl/col_sqe_gen.sv
module col_sqe_gen #(
  parameter int TEST_ON  = 16,
  parameter int TEST_OFF = 2,
  parameter int SQE_GAP  = 20,
  parameter int SQE_LEN  = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_tick,
  input  logic tx_en,
  input  logic rx_act,
  input  logic full_dup,
  input  logic spd_10,
  input  logic col_test,
  input  logic sqe_off,
  output logic col
);
  logic test_act;
  logic sqe_act;
  logic hb_en;
  logic overlap;

  assign hb_en   = spd_10 && !full_dup && !sqe_off;
  assign overlap = tx_en && rx_act;

  col_test_timer #(.TEST_ON(TEST_ON), .TEST_OFF(TEST_OFF)) u_test (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .col_test (col_test),
    .tx_en    (tx_en),
    .test_act (test_act)
  );

  col_sqe_timer #(.SQE_GAP(SQE_GAP), .SQE_LEN(SQE_LEN)) u_sqe (
    .clk      (clk),
    .rst      (rst),
    .bit_tick (bit_tick),
    .tx_en    (tx_en),
    .hb_en    (hb_en),
    .sqe_act  (sqe_act)
  );

  always_ff @(posedge clk) begin
    if (rst) col <= 1'b0;
    else     col <= !full_dup && (overlap || test_act || sqe_act);
  end

  AST_COL_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    (tx_en && rx_act && !full_dup) |=> col); // R1
  AST_FD_QUIET: assert property (@(posedge clk) disable iff (rst)
    full_dup |=> !col); // R2
  AST_RST_LOW: assert property (@(posedge clk)
    rst |=> !col); // R9
endmodule

// File: tb/tb_col_sqe_gen.sv
module tb_col_sqe_gen;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_tick = 1'b1;
  logic tx_en = 1'b0, rx_act = 1'b0, full_dup = 1'b0;
  logic spd_10 = 1'b0, col_test = 1'b0, sqe_off = 1'b0;
  logic col;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  col_sqe_gen dut (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_en(tx_en), .rx_act(rx_act),
    .full_dup(full_dup), .spd_10(spd_10), .col_test(col_test),
    .sqe_off(sqe_off), .col(col)
  );

  // bits: [6]tx_en [5]rx_act [4]full_dup [3]spd_10 [2]col_test [1]sqe_off [0]expected col
  localparam logic [6:0] VEC [8] = '{
    7'b1100001, 7'b1000000, 7'b0100000, 7'b1110000,
    7'b1100011, 7'b0000000, 7'b1101011, 7'b0101010
  };

  task automatic step(int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic check(logic exp, string req);
    n_chk++;
    if (col !== exp) begin
      n_fail++;
      $display("FAIL %s: col=%b expected %b at %0t", req, col, exp, $time);
    end
  endtask

  task automatic quiet_window(int n, string req);
    int highs = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (col) highs++;
    end
    n_chk++;
    if (highs != 0) begin
      n_fail++;
      $display("FAIL %s: col high on %0d cycles expected 0", req, highs);
    end
  endtask

  initial begin
    step(3);
    check(1'b0, "R9 in reset");
    rst = 1'b0;
    step(1);
    check(1'b0, "R9 after reset");

    foreach (VEC[i]) begin
      {tx_en, rx_act, full_dup, spd_10, col_test, sqe_off} = VEC[i][6:1];
      step(1);
      check(VEC[i][0], $sformatf("R1/R2 vector %0d", i));
    end
    {tx_en, rx_act, full_dup, spd_10, col_test, sqe_off} = '0;
    step(40);

    // R3 / R4: collision test, 100 Mb/s
    col_test = 1'b1;
    tx_en = 1'b1;
    step(16); check(1'b0, "R3 before delay");
    step(1);  check(1'b1, "R3 at delay");
    tx_en = 1'b0;
    step(2);  check(1'b1, "R4 before release");
    step(1);  check(1'b0, "R4 at release");

    // R10: no ticks, no test assertion
    bit_tick = 1'b0;
    tx_en = 1'b1;
    quiet_window(30, "R10 tick hold");
    tx_en = 1'b0;
    step(2);
    bit_tick = 1'b1;
    col_test = 1'b0;
    step(5);

    // R2: test mode in full duplex
    full_dup = 1'b1; col_test = 1'b1; tx_en = 1'b1;
    quiet_window(25, "R2 test in full duplex");
    tx_en = 1'b0;
    step(5);
    full_dup = 1'b0; col_test = 1'b0;
    step(2);

    // R5: heartbeat timing
    spd_10 = 1'b1;
    tx_en = 1'b1; step(5);
    tx_en = 1'b0;
    step(21); check(1'b0, "R5 before pulse");
    step(1);  check(1'b1, "R5 pulse start");
    step(9);  check(1'b1, "R5 pulse end");
    step(1);  check(1'b0, "R5 after pulse");
    step(10);

    // R8: cancel by new frame
    tx_en = 1'b1; step(4);
    tx_en = 1'b0; step(10);
    tx_en = 1'b1;
    quiet_window(30, "R8 cancel");
    sqe_off = 1'b1;
    tx_en = 1'b0;
    // R6: suppressed heartbeat
    quiet_window(40, "R6 sqe off");
    sqe_off = 1'b0;

    // R7: 100 Mb/s frame end
    spd_10 = 1'b0;
    tx_en = 1'b1; step(4);
    tx_en = 1'b0;
    quiet_window(40, "R7 no heartbeat at 100");

    // R9: reset mid-pulse
    spd_10 = 1'b1;
    tx_en = 1'b1; step(3);
    tx_en = 1'b0; step(24);
    check(1'b1, "R5 pulse before reset");
    rst = 1'b1; step(1);
    check(1'b0, "R9 reset clears");
    rst = 1'b0;
    quiet_window(15, "R9 quiet after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule